// File: doc/BRIEF.md
# Embedded Core Timer Unit with Staged Watchdog

This block supplies the three timers of an embedded processor core. A free-running time base advances once for each cycle in which the tick enable is high. A fixed-interval timer fires each time a selected time-base bit carries. A programmable interval timer counts down from a stored reload value and can reload itself. A watchdog moves through two warning stages held in the status register. Its third expiry asks for a reset whose kind comes from the control register.

Software programs a 32-bit control word and writes the interval-timer reload value. It acknowledges events by writing ones to the status register. The block drives three interrupt lines. Each line is a status bit gated by its enable. It also drives a one-cycle reset request with a two-bit kind. The logic that carries out the reset lies outside the block.

The watchdog stage is decoded from status bits 31 and 30 into the states QUIET (bit 31 clear), ARMED (31 set, 30 clear) and WARNED (both set). On a watchdog expiry the transitions are: QUIET→ARMED sets bit 31; ARMED→WARNED sets bit 30; WARNED→WARNED latches the reset kind and issues the request. The interval timer has two states, IDLE and RUN. A reload write moves it IDLE→RUN when the value exceeds 1 and the timer is enabled. It goes RUN→IDLE on a reload write of 0 or 1, when the enable is cleared, or at expiry without auto-reload. It stays RUN→RUN on a countdown step or on an expiry with auto-reload.

Top module: `ecore_timer_unit`

## Requirements
- R1: After reset the status word reads 0, all three interrupt lines and the reset request are 0, and the time base is 0.
- R2: Control bits 25:24 (value s) select a fixed-interval period of 2^(FIT_BIT0+STEP*s) ticks counted from reset. Each expiry sets status bit 26, and the timer keeps running for the next period.
- R3: The fixed-interval interrupt equals status bit 26 AND control bit 23.
- R4: A write of the reload register starts the interval timer with the new value only when the value exceeds 1 and control bit 26 is set; otherwise the timer is stopped. Clearing control bit 26 stops a running timer, and setting the bit again does not restart it.
- R5: A running interval timer loaded with N expires on its Nth tick and sets status bit 27. The interval interrupt equals status bit 27 AND control bit 26.
- R6: At expiry the interval timer reloads with the stored value when control bit 22 is set; otherwise it stops.
- R7: Control bits 31:30 (value w) select a watchdog period of 2^(WDT_BIT0+STEP*w) ticks counted from reset.
- R8: A watchdog expiry with status bit 31 clear sets bit 31. With bit 31 set and bit 30 clear, it sets bit 30. The watchdog interrupt equals status bit 30 AND control bit 27.
- R9: A watchdog expiry with status bits 31 and 30 both set copies control bits 29:28 into status bits 29:28. For a non-zero field it pulses the reset request for one cycle with the kind (1 core, 2 chip, 3 system) on the kind output; a zero field gives no pulse.
- R10: Writing a 1 to a status bit clears it. An event that sets the same bit in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base advance enable |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 32 | Control register write data |
| stat_clr_we | input | 1 | Status write-one-to-clear strobe |
| stat_clr_data | input | 32 | Status bits to clear |
| reload_we | input | 1 | Interval reload write strobe |
| reload_wdata | input | PIT_W | Interval reload value |
| stat_o | output | 32 | Status register contents |
| fit_irq | output | 1 | Fixed-interval interrupt |
| pit_irq | output | 1 | Interval timer interrupt |
| wdt_irq | output | 1 | Watchdog interrupt |
| rst_req | output | 1 | One-cycle reset request |
| rst_kind | output | 2 | Kind of requested reset |

## Verification
A wrong watchdog stage shows at the ports by the next watchdog period at the latest. The status word then shows bit 30 set one expiry early, or the reset pulse appears one period early or late. A countdown error in the interval timer moves the rise of status bit 27 and the interval interrupt by the size of the error, which is visible on the tick where expiry is due. A wrong time-base tap or a carry off by one moves the first fixed-interval or watchdog event away from its exact power-of-two tick count. The checks therefore sample one tick before and exactly at each boundary.

// File: rtl/ecore_timer_pkg.sv
package ecore_timer_pkg;

    localparam int REG_W = 32;

    // status bit positions
    localparam int ST_WD_ARM  = 31;
    localparam int ST_WD_WARN = 30;
    localparam int ST_RK_HI   = 29;
    localparam int ST_RK_LO   = 28;
    localparam int ST_PIT     = 27;
    localparam int ST_FIT     = 26;

    localparam logic [REG_W-1:0] ST_IMPL_MASK = 32'hFC00_0000;

    // control bits 31:22 kept as one packed field
    localparam int CT_LO = 22;
    typedef struct packed {
        logic [1:0] wd_sel;
        logic [1:0] wd_kind;
        logic       wd_ie;
        logic       pit_en;
        logic [1:0] fit_sel;
        logic       fit_ie;
        logic       pit_auto;
    } ctrl_t;

    typedef enum logic [1:0] {
        WDS_QUIET  = 2'd0,
        WDS_ARMED  = 2'd1,
        WDS_WARNED = 2'd2
    } wd_stage_e;

    typedef enum logic {
        PIT_IDLE = 1'b0,
        PIT_RUN  = 1'b1
    } pit_state_e;

endpackage

// File: rtl/ecore_timer_tbase.sv
module ecore_timer_tbase #(
    parameter int TB_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    output logic [TB_W-1:0] tb_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            tb_q <= '0;
        else if (tick)
            tb_q <= tb_q + 1'b1;
    end
endmodule

// File: rtl/ecore_timer_tap.sv
module ecore_timer_tap #(
    parameter int BIT0 = 3,
    parameter int STEP = 2,
    localparam int TAP_W = BIT0 + 3 * STEP
) (
    input  logic             tick,
    input  logic [TAP_W-1:0] tb,
    input  logic [1:0]       sel,
    output logic             hit
);
    logic [3:0] carry;

    for (genvar g = 0; g < 4; g++) begin : g_tap
        localparam int K = BIT0 + g * STEP;
        assign carry[g] = tick & (&tb[K-1:0]);
    end

    assign hit = carry[sel];
endmodule

// File: rtl/ecore_timer_pit.sv
module ecore_timer_pit
    import ecore_timer_pkg::*;
#(
    parameter int PIT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic             auto_rl,
    input  logic             ld_we,
    input  logic [PIT_W-1:0] ld_val,
    output logic             expire
);
    localparam logic [PIT_W-1:0] ONE = {{(PIT_W-1){1'b0}}, 1'b1};

    pit_state_e       state_q, state_n;
    logic [PIT_W-1:0] cnt_q, cnt_n;
    logic [PIT_W-1:0] rl_q;
    logic             ld_ok, rl_ok;

    assign ld_ok = ld_val > ONE;
    assign rl_ok = rl_q > ONE;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PIT_IDLE;
            cnt_q   <= '0;
            rl_q    <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            if (ld_we)
                rl_q <= ld_val;
        end
    end

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        expire  = 1'b0;
        unique case (state_q)
            PIT_IDLE: begin
                if (ld_we && ld_ok && en) begin
                    state_n = PIT_RUN;
                    cnt_n   = ld_val;
                end
            end
            PIT_RUN: begin
                if (!en) begin
                    state_n = PIT_IDLE;
                end else if (ld_we) begin
                    if (ld_ok) begin
                        cnt_n = ld_val;
                    end else begin
                        state_n = PIT_IDLE;
                    end
                end else if (tick) begin
                    if (cnt_q == ONE) begin
                        expire = 1'b1;
                        if (auto_rl && rl_ok) begin
                            cnt_n = rl_q;
                        end else begin
                            state_n = PIT_IDLE;
                        end
                    end else begin
                        cnt_n = cnt_q - ONE;
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/ecore_timer_wdog.sv
module ecore_timer_wdog
    import ecore_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic       armed,
    input  logic       warned,
    input  logic [1:0] kind,
    output logic       set_arm,
    output logic       set_warn,
    output logic       take_kind,
    output logic       rst_req,
    output logic [1:0] rst_kind
);
    wd_stage_e stage;
    logic      fire_n;

    always_comb begin
        if (!armed)
            stage = WDS_QUIET;
        else if (!warned)
            stage = WDS_ARMED;
        else
            stage = WDS_WARNED;
    end

    always_comb begin
        set_arm   = 1'b0;
        set_warn  = 1'b0;
        take_kind = 1'b0;
        fire_n    = 1'b0;
        unique case (stage)
            WDS_QUIET:  set_arm  = hit;
            WDS_ARMED:  set_warn = hit;
            WDS_WARNED: begin
                take_kind = hit;
                fire_n    = hit && (kind != 2'd0);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req  <= 1'b0;
            rst_kind <= 2'd0;
        end else begin
            rst_req <= fire_n;
            if (fire_n)
                rst_kind <= kind;
        end
    end
endmodule

// File: rtl/ecore_timer_unit.sv
module ecore_timer_unit
    import ecore_timer_pkg::*;
#(
    parameter int FIT_BIT0 = 9,
    parameter int WDT_BIT0 = 17,
    parameter int STEP     = 4,
    parameter int PIT_W    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctrl_we,
    input  logic [31:0]      ctrl_wdata,
    input  logic             stat_clr_we,
    input  logic [31:0]      stat_clr_data,
    input  logic             reload_we,
    input  logic [PIT_W-1:0] reload_wdata,
    output logic [31:0]      stat_o,
    output logic             fit_irq,
    output logic             pit_irq,
    output logic             wdt_irq,
    output logic             rst_req,
    output logic [1:0]       rst_kind
);
    localparam int FIT_W = FIT_BIT0 + 3 * STEP;
    localparam int TB_W  = WDT_BIT0 + 3 * STEP;

    ctrl_t             ctrl_q;
    logic [REG_W-1:0]  stat_q, stat_n;
    logic [TB_W-1:0]   tb_q;
    logic              fit_hit, wdt_hit, pit_exp;
    logic              wd_arm, wd_warn, wd_take;
    logic              ctrl_unused;

    assign ctrl_unused = ^ctrl_wdata[CT_LO-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (ctrl_we)
            ctrl_q <= ctrl_wdata[REG_W-1:CT_LO];
    end

    ecore_timer_tbase #(.TB_W(TB_W)) u_tbase (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .tb_q (tb_q)
    );

    ecore_timer_tap #(.BIT0(FIT_BIT0), .STEP(STEP)) u_fit_tap (
        .tick(tick),
        .tb  (tb_q[FIT_W-1:0]),
        .sel (ctrl_q.fit_sel),
        .hit (fit_hit)
    );

    ecore_timer_tap #(.BIT0(WDT_BIT0), .STEP(STEP)) u_wdt_tap (
        .tick(tick),
        .tb  (tb_q),
        .sel (ctrl_q.wd_sel),
        .hit (wdt_hit)
    );

    ecore_timer_pit #(.PIT_W(PIT_W)) u_pit (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .en     (ctrl_q.pit_en),
        .auto_rl(ctrl_q.pit_auto),
        .ld_we  (reload_we),
        .ld_val (reload_wdata),
        .expire (pit_exp)
    );

    ecore_timer_wdog u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (wdt_hit),
        .armed    (stat_q[ST_WD_ARM]),
        .warned   (stat_q[ST_WD_WARN]),
        .kind     (ctrl_q.wd_kind),
        .set_arm  (wd_arm),
        .set_warn (wd_warn),
        .take_kind(wd_take),
        .rst_req  (rst_req),
        .rst_kind (rst_kind)
    );

    // clears first, then same-cycle events override
    always_comb begin
        stat_n = stat_q;
        if (stat_clr_we)
            stat_n = stat_n & ~stat_clr_data;
        if (fit_hit)
            stat_n[ST_FIT] = 1'b1;
        if (pit_exp)
            stat_n[ST_PIT] = 1'b1;
        if (wd_arm)
            stat_n[ST_WD_ARM] = 1'b1;
        if (wd_warn)
            stat_n[ST_WD_WARN] = 1'b1;
        if (wd_take)
            stat_n[ST_RK_HI:ST_RK_LO] = ctrl_q.wd_kind;
        stat_n = stat_n & ST_IMPL_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= '0;
        else
            stat_q <= stat_n;
    end

    assign stat_o  = stat_q;
    assign fit_irq = stat_q[ST_FIT]     & ctrl_q.fit_ie;
    assign pit_irq = stat_q[ST_PIT]     & ctrl_q.pit_en;
    assign wdt_irq = stat_q[ST_WD_WARN] & ctrl_q.wd_ie;
endmodule

// File: rtl/ecore_timer_unit_chk.sv
module ecore_timer_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic [31:0] stat_o,
    input logic        fit_irq,
    input logic        pit_irq,
    input logic        wdt_irq,
    input logic        rst_req,
    input logic [1:0]  rst_kind
);
    // R3
    fit_irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fit_irq |-> stat_o[26]);

    // R2
    fit_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_o[26]) |-> $past(tick));

    // R5
    pit_irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pit_irq |-> stat_o[27]);

    // R8
    wdt_irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_irq |-> stat_o[30]);

    // R8
    warn_after_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_o[30]) |-> $past(stat_o[31]));

    // R9
    reset_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R9
    reset_kind_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (rst_kind != 2'd0) && (stat_o[29:28] == rst_kind) && stat_o[31] && stat_o[30]);
endmodule

bind ecore_timer_unit ecore_timer_unit_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .stat_o  (stat_o),
    .fit_irq (fit_irq),
    .pit_irq (pit_irq),
    .wdt_irq (wdt_irq),
    .rst_req (rst_req),
    .rst_kind(rst_kind)
);

// File: tb/ecore_timer_unit_test.sv
`timescale 1ns/1ps
module ecore_timer_unit_test;
    localparam int FB = 3, WB = 6, ST = 2;
    localparam logic [31:0] EN = 32'h0400_0000, AUTO = 32'h0040_0000;

    typedef struct packed {
        logic [31:0] rl;
        logic [31:0] ctrl;
        logic [15:0] ticks;
        logic        e27;
        logic        eirq;
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{32'd4, EN,        16'd3,  1'b0, 1'b0},
        '{32'd4, EN,        16'd4,  1'b1, 1'b1},
        '{32'd1, EN,        16'd12, 1'b0, 1'b0},
        '{32'd0, EN,        16'd12, 1'b0, 1'b0},
        '{32'd6, 32'd0,     16'd12, 1'b0, 1'b0},
        '{32'd7, EN | AUTO, 16'd14, 1'b1, 1'b1},
        '{32'd2, EN,        16'd2,  1'b1, 1'b1}
    };

    logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic        ctrl_we = 1'b0, stat_clr_we = 1'b0, reload_we = 1'b0;
    logic [31:0] ctrl_wdata = '0, stat_clr_data = '0, reload_wdata = '0;
    logic [31:0] stat_o;
    logic        fit_irq, pit_irq, wdt_irq, rst_req;
    logic [1:0]  rst_kind;
    int          n_chk = 0, n_bad = 0, pulses = 0;

    always #2 clk = ~clk;

    ecore_timer_unit #(.FIT_BIT0(FB), .WDT_BIT0(WB), .STEP(ST), .PIT_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .stat_clr_we(stat_clr_we), .stat_clr_data(stat_clr_data),
        .reload_we(reload_we), .reload_wdata(reload_wdata),
        .stat_o(stat_o), .fit_irq(fit_irq), .pit_irq(pit_irq), .wdt_irq(wdt_irq),
        .rst_req(rst_req), .rst_kind(rst_kind)
    );

    always @(negedge clk) if (rst_n && rst_req) pulses++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr_ctrl(input logic [31:0] v);
        @(negedge clk) begin ctrl_we = 1'b1; ctrl_wdata = v; end
        @(negedge clk) ctrl_we = 1'b0;
    endtask

    task automatic wr_reload(input logic [31:0] v);
        @(negedge clk) begin reload_we = 1'b1; reload_wdata = v; end
        @(negedge clk) reload_we = 1'b0;
    endtask

    task automatic clr_stat(input logic [31:0] v);
        @(negedge clk) begin stat_clr_we = 1'b1; stat_clr_data = v; end
        @(negedge clk) stat_clr_we = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk("R1 status", stat_o, 32'h0);
        chk("R1 irqs", {29'd0, fit_irq, pit_irq, wdt_irq}, 32'h0);
        chk("R1 rst_req", {31'd0, rst_req}, 32'h0);

        // R4 R5 R6 vector table
        for (int v = 0; v < 7; v++) begin
            wr_ctrl(VEC[v].ctrl);
            wr_reload(VEC[v].rl);
            clr_stat(32'hFFFF_FFFF);
            run_ticks(int'(VEC[v].ticks));
            chk("R4/R5 pit status bit 27", {31'd0, stat_o[27]}, {31'd0, VEC[v].e27});
            chk("R5 pit_irq", {31'd0, pit_irq}, {31'd0, VEC[v].eirq});
        end

        // R6 one-shot stops
        wr_ctrl(EN); wr_reload(32'd3); clr_stat(32'hFFFF_FFFF);
        run_ticks(3);
        chk("R6 one-shot fires", {31'd0, stat_o[27]}, 32'd1);
        clr_stat(32'h0800_0000);
        run_ticks(6);
        chk("R6 one-shot stays stopped", {31'd0, stat_o[27]}, 32'd0);

        // R6 auto-reload refires
        wr_ctrl(EN | AUTO); wr_reload(32'd3); clr_stat(32'hFFFF_FFFF);
        run_ticks(3);
        clr_stat(32'h0800_0000);
        run_ticks(2);
        chk("R6 auto before period", {31'd0, stat_o[27]}, 32'd0);
        run_ticks(1);
        chk("R6 auto refires", {31'd0, stat_o[27]}, 32'd1);

        // R4 clearing enable stops, re-enable does not restart
        wr_ctrl(EN); wr_reload(32'd5); clr_stat(32'hFFFF_FFFF);
        run_ticks(2);
        wr_ctrl(32'd0); wr_ctrl(EN);
        run_ticks(10);
        chk("R4 stopped by enable clear", {31'd0, stat_o[27]}, 32'd0);

        // R2 R3 fixed interval, period sel 1 = 32 ticks
        do_reset();
        wr_ctrl(32'h0180_0000);
        run_ticks(31);
        chk("R2 fit not yet", {31'd0, fit_irq}, 32'd0);
        run_ticks(1);
        chk("R2/R3 fit at 32", {31'd0, fit_irq}, 32'd1);
        clr_stat(32'h0400_0000);
        chk("R10 w1c fit", {30'd0, stat_o[26], fit_irq}, 32'd0);
        wr_ctrl(32'h0100_0000);
        run_ticks(32);
        chk("R3 gated status", {31'd0, stat_o[26]}, 32'd1);
        chk("R3 gated irq", {31'd0, fit_irq}, 32'd0);
        // R10 set wins over same-cycle clear, period 8, time base at 64
        wr_ctrl(32'h0000_0000);
        clr_stat(32'hFFFF_FFFF);
        run_ticks(7);
        chk("R10 before event", {31'd0, stat_o[26]}, 32'd0);
        @(negedge clk) begin tick = 1'b1; stat_clr_we = 1'b1; stat_clr_data = 32'h0400_0000; end
        @(negedge clk) begin tick = 1'b0; stat_clr_we = 1'b0; end
        chk("R10 set wins", {31'd0, stat_o[26]}, 32'd1);

        // R7 R8 R9 watchdog, period 64, chip reset
        do_reset();
        pulses = 0;
        wr_ctrl(32'h2800_0000);
        run_ticks(63);
        chk("R7 no expiry yet", {30'd0, stat_o[31:30]}, 32'd0);
        run_ticks(1);
        chk("R8 first stage", {30'd0, stat_o[31:30]}, 32'd2);
        chk("R8 no irq stage one", {31'd0, wdt_irq}, 32'd0);
        run_ticks(64);
        chk("R8 second stage", {30'd0, stat_o[31:30]}, 32'd3);
        chk("R8 wdt_irq", {31'd0, wdt_irq}, 32'd1);
        run_ticks(63);
        chk("R9 no early reset", pulses, 0);
        run_ticks(1);
        chk("R9 request", {31'd0, rst_req}, 32'd1);
        chk("R9 kind", {30'd0, rst_kind}, 32'd2);
        chk("R9 kind copied", {30'd0, stat_o[29:28]}, 32'd2);
        @(negedge clk);
        chk("R9 one-cycle strobe", {31'd0, rst_req}, 32'd0);

        // R9 kind 0 gives no request
        do_reset();
        pulses = 0;
        wr_ctrl(32'h0000_0000);
        run_ticks(192);
        chk("R9 kind 0 no pulse", pulses, 0);
        chk("R9 kind 0 stages", {30'd0, stat_o[31:30]}, 32'd3);

        // R7 period sel 1 = 256 ticks, R10 rewind
        do_reset();
        wr_ctrl(32'h4000_0000);
        run_ticks(255);
        chk("R7 sel1 before", {31'd0, stat_o[31]}, 32'd0);
        run_ticks(1);
        chk("R7 sel1 at 256", {31'd0, stat_o[31]}, 32'd1);
        clr_stat(32'h8000_0000);
        chk("R10 w1c bit 31", {30'd0, stat_o[31:30]}, 32'd0);
        run_ticks(256);
        chk("R8 rewound to first stage", {30'd0, stat_o[31:30]}, 32'd2);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule